// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the control state machine that steps a processor core through taking an interrupt and leaving it. An arbiter outside the block presents the most urgent pending request: its IRQ number, its priority value, and a flag saying whether the request may be taken now. From idle, a taken request starts a fixed-length state save. The save drives a push strobe once per stacked word. A vector fetch for the latched IRQ follows, then the handler runs until a completion pulse arrives. After completion the block either pops the saved state back over a fixed number of cycles or moves straight on to another handler.

Two shortcuts reduce the time spent stacking. The first is tail-chaining: when a handler completes and a qualifying request is already waiting, the pop and the following push are both skipped, and the block goes to the new vector fetch through a one-cycle chaining state. The second is late arrival: a request that is strictly more urgent and appears while state is being saved, or while the vector is being fetched, takes over the vector fetch. The save itself carries on unchanged. When the handler of such a late request completes, the exception it displaced is announced as pending again and is fetched without any pop in between.

Lower priority values mean more urgent requests. Only one nesting level is sequenced. A more urgent request that turns up while a handler runs is reported on an output and nothing else happens.

Top module: `exc_seq`

## Requirements
- R1: After reset the block is idle, and push_o, pop_o, vec_req_o, handler_start_o, late_o, repend_o and preempt_o are all low.
- R2: From idle, a cycle with req_valid_i high latches req_irq_i and req_prio_i. From the next cycle, push_o is high for exactly SAVE_CYC consecutive cycles.
- R3: After the save, vec_req_o is high for FETCH_CYC cycles with vec_irq_o equal to the latched IRQ. handler_start_o then pulses for one cycle, in the first handler cycle.
- R4: During the save or the fetch, req_valid_i with req_prio_i numerically lower than the latched priority replaces the latched IRQ and priority and sets late_o. An equal or higher priority value has no effect. A replacement during the fetch restarts the fetch count.
- R5: A late arrival neither shortens nor lengthens the save: push_o still stays high for exactly SAVE_CYC cycles.
- R6: done_i in a handler cycle, with late_o low and req_valid_i high, latches the request and gives one chaining cycle and then a new fetch. pop_o is never raised in between.
- R7: done_i in a handler cycle, with late_o low and req_valid_i low, gives pop_o high for exactly POP_CYC cycles, followed by idle.
- R8: done_i in a handler cycle with late_o high raises repend_o in that same cycle, with repend_irq_o equal to the IRQ first taken from idle or by chaining. late_o clears. After one chaining cycle that original IRQ is fetched, with no pop.
- R9: While a handler runs, vec_irq_o does not change. preempt_o is high exactly in handler cycles where req_valid_i is high and req_prio_i is numerically lower than the active priority, and the state does not change because of it.
- R10: done_i outside a handler cycle is ignored, and req_valid_i is ignored during the pop and chaining cycles. The outputs follow the state sequence as if the input had been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Arbiter's current request qualifies to be taken |
| req_irq_i | input | IRQ_W | IRQ number of the arbiter's current request |
| req_prio_i | input | PRIO_W | Priority value of that request (lower is more urgent) |
| done_i | input | 1 | Handler completion pulse |
| push_o | output | 1 | One stacked word saved this cycle |
| pop_o | output | 1 | One stacked word restored this cycle |
| vec_req_o | output | 1 | Vector fetch in progress |
| vec_irq_o | output | IRQ_W | IRQ being fetched or serviced |
| handler_start_o | output | 1 | First cycle of handler execution |
| late_o | output | 1 | The handler in flight was taken by late arrival |
| repend_o | output | 1 | Displaced exception must be marked pending again |
| repend_irq_o | output | IRQ_W | IRQ number of the displaced exception |
| preempt_o | output | 1 | More urgent request seen during a handler (not sequenced) |

## Verification
The assertions assume that done_i is a single-cycle pulse, that the arbiter's IRQ and priority are meaningful whenever req_valid_i is high, and that the arbiter re-marks the displaced IRQ when repend_o pulses. The directed stimulus raises done_i for one cycle at a time and presents each request together with its priority. The random phase also places completion pulses in saving, fetching, popping and idle cycles. A cycle-level reference model that accepts any input sequence is compared against the block's outputs, so those pulses exercise the ignore rules without breaking what the assertions take for granted.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_SAVE      = 3'd1,
      ST_FETCH     = 3'd2,
      ST_HANDLER   = 3'd3,
      ST_POP       = 3'd4,
      ST_TAILCHAIN = 3'd5
   } seq_st_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/exc_seq_phase_cnt.sv
module exc_seq_phase_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] len_m1_i,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == len_m1_i);

endmodule

// File: rtl/exc_seq_irq_track.sv
module exc_seq_irq_track #(
   parameter int IRQ_W  = 5,
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_new_i,
   input  logic              cap_late_i,
   input  logic              cap_orig_i,
   input  logic [IRQ_W-1:0]  req_irq_i,
   input  logic [PRIO_W-1:0] req_prio_i,
   output logic [IRQ_W-1:0]  lat_irq_o,
   output logic [IRQ_W-1:0]  orig_irq_o,
   output logic              more_urgent_o
);

   logic [IRQ_W-1:0]  lat_irq_q,  orig_irq_q;
   logic [PRIO_W-1:0] lat_prio_q, orig_prio_q;

   // Latched request: replaced on a new take, a late arrival or a return to the original.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_irq_q  <= '0;
         lat_prio_q <= '0;
      end else if (cap_new_i || cap_late_i) begin
         lat_irq_q  <= req_irq_i;
         lat_prio_q <= req_prio_i;
      end else if (cap_orig_i) begin
         lat_irq_q  <= orig_irq_q;
         lat_prio_q <= orig_prio_q;
      end
   end

   // Original request: only a take from idle or a chained take sets it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         orig_irq_q  <= '0;
         orig_prio_q <= '0;
      end else if (cap_new_i) begin
         orig_irq_q  <= req_irq_i;
         orig_prio_q <= req_prio_i;
      end
   end

   assign lat_irq_o     = lat_irq_q;
   assign orig_irq_o    = orig_irq_q;
   assign more_urgent_o = (req_prio_i < lat_prio_q);

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
   import exc_seq_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int SAVE_CYC  = 8,
   parameter int FETCH_CYC = 2,
   parameter int POP_CYC   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   input  logic             more_urgent_i,
   input  logic             done_i,
   input  logic             cnt_last_i,
   output seq_st_e          st_o,
   output logic             cap_new_o,
   output logic             cap_late_o,
   output logic             cap_orig_o,
   output logic             cnt_clr_o,
   output logic             cnt_en_o,
   output logic [CNT_W-1:0] len_m1_o,
   output logic             hs_o,
   output logic             late_o,
   output logic             repend_o,
   output logic             preempt_o
);

   seq_st_e st_q, st_d;
   logic    late_q, late_set, late_clr;
   logic    hs_q, hs_set;
   logic    urgent;

   assign urgent = req_valid_i && more_urgent_i;

   always_comb begin
      st_d       = st_q;
      cap_new_o  = 1'b0;
      cap_late_o = 1'b0;
      cap_orig_o = 1'b0;
      cnt_clr_o  = 1'b0;
      cnt_en_o   = 1'b0;
      late_set   = 1'b0;
      late_clr   = 1'b0;
      hs_set     = 1'b0;
      repend_o   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid_i) begin
               cap_new_o = 1'b1;
               cnt_clr_o = 1'b1;
               st_d      = ST_SAVE;
            end
         end
         ST_SAVE: begin
            if (urgent) begin
               cap_late_o = 1'b1;
               late_set   = 1'b1;
            end
            if (cnt_last_i) begin
               cnt_clr_o = 1'b1;
               st_d      = ST_FETCH;
            end else begin
               cnt_en_o = 1'b1;
            end
         end
         ST_FETCH: begin
            if (urgent) begin
               cap_late_o = 1'b1;
               late_set   = 1'b1;
               cnt_clr_o  = 1'b1;
            end else if (cnt_last_i) begin
               cnt_clr_o = 1'b1;
               hs_set    = 1'b1;
               st_d      = ST_HANDLER;
            end else begin
               cnt_en_o = 1'b1;
            end
         end
         ST_HANDLER: begin
            if (done_i) begin
               late_clr = 1'b1;
               if (late_q) begin
                  repend_o   = 1'b1;
                  cap_orig_o = 1'b1;
                  st_d       = ST_TAILCHAIN;
               end else if (req_valid_i) begin
                  cap_new_o = 1'b1;
                  st_d      = ST_TAILCHAIN;
               end else begin
                  cnt_clr_o = 1'b1;
                  st_d      = ST_POP;
               end
            end
         end
         ST_TAILCHAIN: begin
            cnt_clr_o = 1'b1;
            st_d      = ST_FETCH;
         end
         ST_POP: begin
            if (cnt_last_i) begin
               st_d = ST_IDLE;
            end else begin
               cnt_en_o = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st_q)
         ST_SAVE:  len_m1_o = CNT_W'(SAVE_CYC - 1);
         ST_FETCH: len_m1_o = CNT_W'(FETCH_CYC - 1);
         ST_POP:   len_m1_o = CNT_W'(POP_CYC - 1);
         default:  len_m1_o = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         late_q <= 1'b0;
         hs_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         hs_q <= hs_set;
         if (late_set) begin
            late_q <= 1'b1;
         end else if (late_clr) begin
            late_q <= 1'b0;
         end
      end
   end

   assign st_o      = st_q;
   assign hs_o      = hs_q;
   assign late_o    = late_q;
   assign preempt_o = (st_q == ST_HANDLER) && urgent;

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int IRQ_W     = 5,
   parameter int PRIO_W    = 3,
   parameter int SAVE_CYC  = 8,
   parameter int FETCH_CYC = 2,
   parameter int POP_CYC   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [IRQ_W-1:0]  req_irq_i,
   input  logic [PRIO_W-1:0] req_prio_i,
   input  logic              done_i,
   output logic              push_o,
   output logic              pop_o,
   output logic              vec_req_o,
   output logic [IRQ_W-1:0]  vec_irq_o,
   output logic              handler_start_o,
   output logic              late_o,
   output logic              repend_o,
   output logic [IRQ_W-1:0]  repend_irq_o,
   output logic              preempt_o
);

   localparam int MAX_CYC = max3(SAVE_CYC, FETCH_CYC, POP_CYC);
   localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (IRQ_W < 1 || PRIO_W < 1) begin : g_bad_width
         $error("exc_seq: IRQ_W and PRIO_W must be at least 1");
      end
      if (SAVE_CYC < 1 || FETCH_CYC < 1 || POP_CYC < 1) begin : g_bad_len
         $error("exc_seq: phase lengths must be at least 1");
      end
   endgenerate

   seq_st_e          st_w;
   logic             cap_new, cap_late, cap_orig;
   logic             cnt_clr, cnt_en, cnt_last;
   logic [CNT_W-1:0] len_m1;
   logic             more_urgent;
   logic [IRQ_W-1:0] lat_irq, orig_irq;

   exc_seq_ctrl #(
      .CNT_W     (CNT_W),
      .SAVE_CYC  (SAVE_CYC),
      .FETCH_CYC (FETCH_CYC),
      .POP_CYC   (POP_CYC)
   ) ctrl_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid_i   (req_valid_i),
      .more_urgent_i (more_urgent),
      .done_i        (done_i),
      .cnt_last_i    (cnt_last),
      .st_o          (st_w),
      .cap_new_o     (cap_new),
      .cap_late_o    (cap_late),
      .cap_orig_o    (cap_orig),
      .cnt_clr_o     (cnt_clr),
      .cnt_en_o      (cnt_en),
      .len_m1_o      (len_m1),
      .hs_o          (handler_start_o),
      .late_o        (late_o),
      .repend_o      (repend_o),
      .preempt_o     (preempt_o)
   );

   exc_seq_phase_cnt #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (cnt_clr),
      .en_i     (cnt_en),
      .len_m1_i (len_m1),
      .last_o   (cnt_last)
   );

   exc_seq_irq_track #(
      .IRQ_W  (IRQ_W),
      .PRIO_W (PRIO_W)
   ) track_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cap_new_i     (cap_new),
      .cap_late_i    (cap_late),
      .cap_orig_i    (cap_orig),
      .req_irq_i     (req_irq_i),
      .req_prio_i    (req_prio_i),
      .lat_irq_o     (lat_irq),
      .orig_irq_o    (orig_irq),
      .more_urgent_o (more_urgent)
   );

   assign push_o       = (st_w == ST_SAVE);
   assign pop_o        = (st_w == ST_POP);
   assign vec_req_o    = (st_w == ST_FETCH);
   assign vec_irq_o    = lat_irq;
   assign repend_irq_o = orig_irq;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
   import exc_seq_pkg::*;
#(
   parameter int IRQ_W    = 5,
   parameter int SAVE_CYC = 8,
   parameter int POP_CYC  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input seq_st_e          st_w,
   input logic             push_o,
   input logic             pop_o,
   input logic             vec_req_o,
   input logic [IRQ_W-1:0] vec_irq_o,
   input logic             handler_start_o,
   input logic             late_o,
   input logic             repend_o
);

   int push_run, pop_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_run <= 0;
         pop_run  <= 0;
      end else begin
         push_run <= push_o ? push_run + 1 : 0;
         pop_run  <= pop_o  ? pop_run  + 1 : 0;
      end
   end

   p_push_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(push_o) |-> (push_run == SAVE_CYC));

   p_pop_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pop_o) |-> (pop_run == POP_CYC));

   p_start_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      handler_start_o |-> $past(vec_req_o));

   p_late_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(late_o) |-> $past(push_o || vec_req_o));

   p_repend_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
      repend_o |-> late_o);

   p_chain_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_w == ST_TAILCHAIN) |=> (vec_req_o && !pop_o));

   p_irq_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_w == ST_HANDLER && $past(st_w == ST_HANDLER)) |-> $stable(vec_irq_o));

endmodule

bind exc_seq exc_seq_chk #(
   .IRQ_W    (IRQ_W),
   .SAVE_CYC (SAVE_CYC),
   .POP_CYC  (POP_CYC)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .st_w            (st_w),
   .push_o          (push_o),
   .pop_o           (pop_o),
   .vec_req_o       (vec_req_o),
   .vec_irq_o       (vec_irq_o),
   .handler_start_o (handler_start_o),
   .late_o          (late_o),
   .repend_o        (repend_o)
);

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;

   localparam int IRQ_W  = 5;
   localparam int PRIO_W = 3;
   localparam int SAVE_N = 8;
   localparam int FETCH_N = 2;
   localparam int POP_N  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [IRQ_W-1:0]  req_irq = '0;
   logic [PRIO_W-1:0] req_prio = '0;
   logic              done = 1'b0;
   logic              push, pop, vreq, hs, late, rep, pre;
   logic [IRQ_W-1:0]  virq, rep_irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   exc_seq #(
      .IRQ_W(IRQ_W), .PRIO_W(PRIO_W),
      .SAVE_CYC(SAVE_N), .FETCH_CYC(FETCH_N), .POP_CYC(POP_N)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_irq_i(req_irq), .req_prio_i(req_prio),
      .done_i(done),
      .push_o(push), .pop_o(pop), .vec_req_o(vreq), .vec_irq_o(virq),
      .handler_start_o(hs), .late_o(late), .repend_o(rep),
      .repend_irq_o(rep_irq), .preempt_o(pre)
   );

   // Reference model: 0 idle, 1 save, 2 fetch, 3 handler, 4 pop, 5 chain
   int m_st = 0, m_cnt = 0;
   int m_lat_irq = 0, m_lat_prio = 0, m_orig_irq = 0, m_orig_prio = 0;
   bit m_late = 0, m_hs = 0;
   int n_push = 0, n_pop = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_late = 0; m_hs = 0;
         m_lat_irq = 0; m_lat_prio = 0; m_orig_irq = 0; m_orig_prio = 0;
      end else begin
         bit urg;
         urg  = req_valid && (int'(req_prio) < m_lat_prio);
         m_hs = 0;
         case (m_st)
            0: if (req_valid) begin
                  m_lat_irq = req_irq; m_lat_prio = req_prio;
                  m_orig_irq = req_irq; m_orig_prio = req_prio;
                  m_st = 1; m_cnt = 0;
               end
            1: begin
                  if (urg) begin m_lat_irq = req_irq; m_lat_prio = req_prio; m_late = 1; end
                  if (m_cnt == SAVE_N-1) begin m_st = 2; m_cnt = 0; end
                  else m_cnt++;
               end
            2: begin
                  if (urg) begin
                     m_lat_irq = req_irq; m_lat_prio = req_prio; m_late = 1; m_cnt = 0;
                  end else if (m_cnt == FETCH_N-1) begin
                     m_st = 3; m_hs = 1; m_cnt = 0;
                  end else m_cnt++;
               end
            3: if (done) begin
                  if (m_late) begin
                     m_lat_irq = m_orig_irq; m_lat_prio = m_orig_prio; m_late = 0; m_st = 5;
                  end else if (req_valid) begin
                     m_lat_irq = req_irq; m_lat_prio = req_prio;
                     m_orig_irq = req_irq; m_orig_prio = req_prio; m_st = 5;
                  end else begin
                     m_st = 4; m_cnt = 0;
                  end
               end
            5: begin m_st = 2; m_cnt = 0; end
            4: if (m_cnt == POP_N-1) m_st = 0; else m_cnt++;
            default: m_st = 0;
         endcase
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2", "push_o", push, m_st == 1);
         chk("R7", "pop_o", pop, m_st == 4);
         chk("R3", "vec_req_o", vreq, m_st == 2);
         if (m_st == 2 || m_st == 3) chk("R4", "vec_irq_o", virq, m_lat_irq);
         chk("R3", "handler_start_o", hs, m_hs);
         chk("R4", "late_o", late, m_late);
         chk("R9", "preempt_o", pre, m_st == 3 && req_valid && int'(req_prio) < m_lat_prio);
         chk("R8", "repend_o", rep, m_st == 3 && done && m_late);
         if (m_st == 3 && done && m_late) chk("R8", "repend_irq_o", rep_irq, m_orig_irq);
         if (push) n_push++;
         if (pop) n_pop++;
      end
   end

   task automatic drive(input bit v, input int irq, input int prio, input bit d);
      @(posedge clk); #1;
      req_valid = v; req_irq = IRQ_W'(irq); req_prio = PRIO_W'(prio); done = d;
   endtask

   task automatic quiet(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
   endtask

   initial begin
      #20000000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #9;
      chk("R1", "reset push", push, 0);
      chk("R1", "reset vreq", vreq, 0);
      chk("R1", "reset hs", hs, 0);
      chk("R1", "reset late", late, 0);
      chk("R1", "reset pop", pop, 0);
      @(posedge clk); #1; rst_n = 1;
      quiet(2);

      // Plain entry and return with a normal pop.
      n_push = 0; n_pop = 0;
      drive(1, 5, 3, 0); quiet(SAVE_N + FETCH_N + 3);
      drive(0, 0, 0, 1); quiet(POP_N + 3);
      chk("R2", "push count plain", n_push, SAVE_N);
      chk("R7", "pop count plain", n_pop, POP_N);

      // Late arrival in save, an equal priority ignored, then return to original.
      n_push = 0; n_pop = 0;
      drive(1, 5, 3, 0); quiet(2);
      drive(1, 7, 3, 0);             // equal priority: no effect (R4)
      drive(1, 9, 1, 0); quiet(SAVE_N + FETCH_N + 2);
      chk("R4", "late flag after save", late, 1);
      chk("R5", "push count with late", n_push, SAVE_N);
      drive(0, 0, 0, 1); quiet(FETCH_N + 3);
      chk("R8", "fetched original", virq, 5);
      chk("R8", "no pop on repend", n_pop, 0);
      drive(0, 0, 0, 1); quiet(POP_N + 3);

      // Late arrival during fetch restarts the fetch.
      drive(1, 4, 6, 0); quiet(SAVE_N);
      drive(1, 11, 2, 0); quiet(FETCH_N + 3);
      chk("R4", "fetch replaced irq", virq, 11);
      drive(0, 0, 0, 1); quiet(FETCH_N + 3);
      drive(0, 0, 0, 1); quiet(POP_N + 3);

      // Tail chain with no pop, preemption report, ignored done and requests.
      n_pop = 0;
      drive(1, 3, 5, 0); drive(0, 0, 0, 1); quiet(SAVE_N + FETCH_N + 3);
      drive(1, 1, 0, 0);             // more urgent in handler: reported only (R9)
      chk("R9", "irq kept on preempt", virq, 3);
      drive(1, 2, 4, 1); quiet(FETCH_N + 3);
      chk("R6", "no pop on chain", n_pop, 0);
      chk("R6", "chained irq", virq, 2);
      drive(0, 0, 0, 1); drive(1, 6, 2, 1); quiet(POP_N + 3);   // R10 during pop
      chk("R10", "idle after pop with ignored inputs", push, 0);

      // Random phase.
      for (int i = 0; i < 3000; i++) begin
         drive(($urandom % 3) == 0, $urandom % 32, $urandom % 8, ($urandom % 9) == 0);
      end
      quiet(40);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule